// File: doc/BRIEF.md
# Bidirectional latch/register bus transceiver

This block sits between two 18-bit buses, called A and B, and carries a word in each direction through a storage element of its own. In each direction a latch-enable input and a strobe input choose one of three behaviours. With the latch enable high, the receiving port shows the sending port's word with no clock delay (pass mode). With the latch enable low, the stored word is shown. That stored word is replaced only when the strobe goes from low to high (load mode); otherwise it stays as it is (hold mode). A drive-enable output for each port lets the surrounding logic build a tri-state or multiplexed bus.

The strobes are treated as data. They are sampled on the block clock `clk`, and a rising strobe is recognised at the first clock edge that sees it high after a low sample. Each strobe level must therefore last at least one clock cycle. While the latch enable is high the storage element follows the input at every clock edge, so when the latch enable falls, the word shown while the enable was last high at a clock edge is kept. The A-to-B output enable is active high. The B-to-A output enable is active low. The two directions share nothing except clock and reset.

Top module: `bidir_stage_xcvr`

## Requirements
- R1: Every one of the WIDTH (default 18) bits in each direction behaves identically, so any bit pattern, including all ones and alternating bits, passes unchanged.
- R2: While `a2b_le` is 1, `pb_o` equals `pa_i` in the same cycle; while `b2a_le` is 1, `pa_o` equals `pb_i` in the same cycle.
- R3: While the latch enable of a direction is 0 and its strobe shows no rising transition, that direction's output data does not change.
- R4: When the latch enable is 0 and a clock edge sees the strobe at 1 after a 0 at the previous edge, the input word present at that edge is stored and shown from that edge on.
- R5: `pb_oe` is 1 exactly when `a2b_oe` is 1; with `a2b_oe` at 0 the B port is never driven.
- R6: `pa_oe` is 1 exactly when `b2a_oe_n` is 0 (active low); with `b2a_oe_n` at 1 the A port is never driven.
- R7: When the latch enable falls, the output shows the input word sampled at the last clock edge at which the latch enable was still 1, even if the input changes together with the enable.
- R8: A strobe rise seen while the latch enable is 1, or a strobe already at 1 when reset ends, causes no later load; a new load needs the strobe to be sampled at 0 first.
- R9: The two directions are independent; both drive enables may be 1 in the same cycle, and each port then carries its own direction's word.
- R10: While `rst_n` is 0, both stored words are 0, and the strobe history counts as high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_i | input | WIDTH | Word received on the A bus |
| pb_i | input | WIDTH | Word received on the B bus |
| a2b_le | input | 1 | A-to-B latch enable (1 = pass) |
| a2b_stb | input | 1 | A-to-B strobe; a rising level loads the store |
| a2b_oe | input | 1 | A-to-B output enable, active high |
| b2a_le | input | 1 | B-to-A latch enable (1 = pass) |
| b2a_stb | input | 1 | B-to-A strobe; a rising level loads the store |
| b2a_oe_n | input | 1 | B-to-A output enable, active low |
| pa_o | output | WIDTH | Word to drive onto the A bus |
| pa_oe | output | 1 | Drive enable for the A bus |
| pb_o | output | WIDTH | Word to drive onto the B bus |
| pb_oe | output | 1 | Drive enable for the B bus |

## Verification
Two pairs of events can fall in the same cycle. One is a latch-enable fall together with a change of the input word, where the kept value must be the old word (R7). The other is a strobe rise while the latch enable is still high, which must not load anything later (R8). Directed steps produce both coincidences. A long pseudo-random sweep over all control combinations in both directions at once also produces them, and it drives both output enables on together (R9). Each check is judged against a cycle-level model in the bench. That model records the input word at every clock edge where the latch enable is high or a strobe rise is seen. The bench counts cycles in which both ports drive at once as contention, but does not treat them as errors.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Behaviour of one direction's storage element for the coming clock edge
  typedef enum logic [1:0] {
    M_HOLD = 2'd0,
    M_PASS = 2'd1,
    M_LOAD = 2'd2
  } st_mode_e;

  // Pass wins over load; otherwise the store keeps its word
  function automatic st_mode_e pick_mode(input logic le, input logic rise);
    if (le)   return M_PASS;
    if (rise) return M_LOAD;
    return M_HOLD;
  endfunction

  // Rising level: high now, low at the previous sample
  function automatic logic rise_of(input logic now_lvl, input logic before_lvl);
    return now_lvl & ~before_lvl;
  endfunction

  // Map an enable pin to a drive request according to its polarity
  function automatic logic drive_on(input logic oe, input logic act_low);
    return act_low ? ~oe : oe;
  endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic rise_o
);
  import xcvr_pkg::*;

  logic prev_q;

  // History starts high so a strobe held high across reset is not a rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= stb_i;
  end

  assign rise_o = rise_of(stb_i, prev_q);
endmodule

// File: rtl/xcvr_cell.sv
module xcvr_cell (
  input  logic               clk,
  input  logic               rst_n,
  input  xcvr_pkg::st_mode_e mode_i,
  input  logic               d_i,
  output logic               q_o
);
  import xcvr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q_o <= 1'b0;
    else if (mode_i != M_HOLD) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int WIDTH         = 18,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   d_i,
  input  logic               le_i,
  input  logic               stb_i,
  input  logic               oe_i,
  output logic [WIDTH-1:0]   q_o,
  output logic               drv_o,
  output logic               rise_o,
  output xcvr_pkg::st_mode_e mode_o
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] stored;

  xcvr_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_i  (stb_i),
    .rise_o (rise_o)
  );

  assign mode_o = pick_mode(le_i, rise_o);

  // One identical storage cell per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    xcvr_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_o),
      .d_i    (d_i[i]),
      .q_o    (stored[i])
    );
  end

  // Pass mode bypasses the store with no clock delay
  assign q_o = le_i ? d_i : stored;

  if (OE_ACTIVE_LOW) begin : g_oe_low
    assign drv_o = drive_on(oe_i, 1'b1);
  end else begin : g_oe_high
    assign drv_o = drive_on(oe_i, 1'b0);
  end
endmodule

// File: rtl/bidir_stage_xcvr.sv
module bidir_stage_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pa_i,
  input  logic [WIDTH-1:0] pb_i,
  input  logic             a2b_le,
  input  logic             a2b_stb,
  input  logic             a2b_oe,
  input  logic             b2a_le,
  input  logic             b2a_stb,
  input  logic             b2a_oe_n,
  output logic [WIDTH-1:0] pa_o,
  output logic             pa_oe,
  output logic [WIDTH-1:0] pb_o,
  output logic             pb_oe
);
  import xcvr_pkg::*;

  // Internal events brought out by name for the checker
  logic     a2b_rise;
  logic     b2a_rise;
  st_mode_e a2b_mode;
  st_mode_e b2a_mode;

  xcvr_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_a2b (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (pa_i),
    .le_i   (a2b_le),
    .stb_i  (a2b_stb),
    .oe_i   (a2b_oe),
    .q_o    (pb_o),
    .drv_o  (pb_oe),
    .rise_o (a2b_rise),
    .mode_o (a2b_mode)
  );

  xcvr_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_b2a (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (pb_i),
    .le_i   (b2a_le),
    .stb_i  (b2a_stb),
    .oe_i   (b2a_oe_n),
    .q_o    (pa_o),
    .drv_o  (pa_oe),
    .rise_o (b2a_rise),
    .mode_o (b2a_mode)
  );
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WIDTH-1:0]   pa_i,
  input logic [WIDTH-1:0]   pb_i,
  input logic               a2b_le,
  input logic               a2b_stb,
  input logic               a2b_oe,
  input logic               b2a_le,
  input logic               b2a_stb,
  input logic               b2a_oe_n,
  input logic [WIDTH-1:0]   pa_o,
  input logic               pa_oe,
  input logic [WIDTH-1:0]   pb_o,
  input logic               pb_oe,
  input logic               a2b_rise,
  input logic               b2a_rise,
  input xcvr_pkg::st_mode_e a2b_mode,
  input xcvr_pkg::st_mode_e b2a_mode
);
  import xcvr_pkg::*;

  assert_ab_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a2b_le |-> pb_o == pa_i);
  assert_ba_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b2a_le |-> pa_o == pb_i);

  assert_ab_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!a2b_le && !a2b_rise) ##1 !a2b_le |-> $stable(pb_o));
  assert_ba_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!b2a_le && !b2a_rise) ##1 !b2a_le |-> $stable(pa_o));

  assert_ab_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a2b_mode == M_LOAD) ##1 !a2b_le |-> pb_o == $past(pa_i));
  assert_ba_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (b2a_mode == M_LOAD) ##1 !b2a_le |-> pa_o == $past(pb_i));

  assert_ab_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !a2b_oe |-> !pb_oe);
  assert_ba_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    b2a_oe_n |-> !pa_oe);
  assert_ba_oe_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !b2a_oe_n |-> pa_oe);

  assert_ab_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a2b_le ##1 !a2b_le |-> pb_o == $past(pa_i));
  assert_ba_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b2a_le ##1 !b2a_le |-> pa_o == $past(pb_i));

  assert_ab_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    a2b_rise |-> a2b_stb && !$past(a2b_stb));
  assert_ba_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    b2a_rise |-> b2a_stb && !$past(b2a_stb));
endmodule

bind bidir_stage_xcvr xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pa_i     (pa_i),
  .pb_i     (pb_i),
  .a2b_le   (a2b_le),
  .a2b_stb  (a2b_stb),
  .a2b_oe   (a2b_oe),
  .b2a_le   (b2a_le),
  .b2a_stb  (b2a_stb),
  .b2a_oe_n (b2a_oe_n),
  .pa_o     (pa_o),
  .pa_oe    (pa_oe),
  .pb_o     (pb_o),
  .pb_oe    (pb_oe),
  .a2b_rise (a2b_rise),
  .b2a_rise (b2a_rise),
  .a2b_mode (a2b_mode),
  .b2a_mode (b2a_mode)
);

// File: tb/sim_bidir_stage_xcvr.sv
module sim_bidir_stage_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [W-1:0] pa_i, pb_i, pa_o, pb_o;
  logic         a2b_le, a2b_stb, a2b_oe, b2a_le, b2a_stb, b2a_oe_n;
  logic         pa_oe, pb_oe;

  bidir_stage_xcvr #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pa_i(pa_i), .pb_i(pb_i),
    .a2b_le(a2b_le), .a2b_stb(a2b_stb), .a2b_oe(a2b_oe),
    .b2a_le(b2a_le), .b2a_stb(b2a_stb), .b2a_oe_n(b2a_oe_n),
    .pa_o(pa_o), .pa_oe(pa_oe), .pb_o(pb_o), .pb_oe(pb_oe)
  );

  int n_run = 0, n_fail = 0, n_cont = 0;

  // Bench model: stored word and strobe history per direction
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic         p_ab = 1'b1, p_ba = 1'b1;
  logic         r_ab = 1'b0, r_ba = 1'b0, l_ab = 1'b0, l_ba = 1'b0;
  logic [31:0]  lfsr = 32'h1234_5677;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One clock edge; the model records words as the requirements state
  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; p_ab = 1'b1; p_ba = 1'b1;
      r_ab = 1'b0; r_ba = 1'b0; l_ab = 1'b0; l_ba = 1'b0;
    end else begin
      r_ab = a2b_stb && !p_ab;
      r_ba = b2a_stb && !p_ba;
      l_ab = a2b_le;
      l_ba = b2a_le;
      if (a2b_le || r_ab) m_ab = pa_i;
      if (b2a_le || r_ba) m_ba = pb_i;
      p_ab = a2b_stb;
      p_ba = b2a_stb;
    end
    @(negedge clk);
  endtask

  function automatic string mode_tag(input logic le, input logic rise, input logic last_le);
    if (le)      return "R2";
    if (rise)    return "R4";
    if (last_le) return "R7";
    return "R3";
  endfunction

  task automatic check_ports(input string tag_ab, input string tag_ba);
    chk1("R5 B drive enable", pb_oe, a2b_oe);
    chk1("R6 A drive enable", pa_oe, !b2a_oe_n);
    if (pb_oe) chk({tag_ab, " B data"}, pb_o, a2b_le ? pa_i : m_ab);
    if (pa_oe) chk({tag_ba, " A data"}, pa_o, b2a_le ? pb_i : m_ba);
    if (pb_oe && pa_oe) n_cont++;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pa_i = 18'h15A5A; pb_i = 18'h0A5A5;
    a2b_le = 1'b0; a2b_stb = 1'b1; a2b_oe = 1'b1;
    b2a_le = 1'b0; b2a_stb = 1'b1; b2a_oe_n = 1'b0;
    @(negedge clk);
    repeat (3) step();
    chk("R10 reset B store", pb_o, '0);
    chk("R10 reset A store", pa_o, '0);

    // Strobes held high across reset release: no load
    rst_n = 1'b1;
    step(); step();
    chk("R8 strobe high at reset end B", pb_o, '0);
    chk("R8 strobe high at reset end A", pa_o, '0);

    // Low then high: loads
    a2b_stb = 1'b0; b2a_stb = 1'b0; step();
    pa_i = 18'h2F0F1; pb_i = 18'h10F0E; a2b_stb = 1'b1; b2a_stb = 1'b1; step();
    chk("R4 load B", pb_o, 18'h2F0F1);
    chk("R4 load A", pa_o, 18'h10F0E);
    check_ports("R4", "R4");

    // R1 width patterns in pass mode
    a2b_le = 1'b1; b2a_le = 1'b1; pa_i = 18'h3FFFF; pb_i = 18'h2AAAA; step();
    chk("R1 all ones B", pb_o, 18'h3FFFF);
    chk("R1 alternating A", pa_o, 18'h2AAAA);
    pa_i = 18'h15555; pb_i = 18'h00001; #1;
    chk("R1 R2 same-cycle pass B", pb_o, 18'h15555);
    chk("R1 R2 same-cycle pass A", pa_o, 18'h00001);
    step();

    // R7: enable fall together with new input keeps old word
    a2b_le = 1'b0; b2a_le = 1'b0; pa_i = 18'h00BAD; pb_i = 18'h0C0DE; step();
    chk("R7 close B", pb_o, 18'h15555);
    chk("R7 close A", pa_o, 18'h00001);

    // R8: strobe rise during pass, then enable fall with strobe high: no load
    a2b_le = 1'b1; a2b_stb = 1'b0; step();
    a2b_stb = 1'b1; pa_i = 18'h01234; step();
    a2b_le = 1'b0; pa_i = 18'h3ABCD; repeat (3) step();
    chk("R8 rise during pass B", pb_o, 18'h01234);

    // R9: both ports driving at once, each its own word
    a2b_le = 1'b1; b2a_le = 1'b1; a2b_oe = 1'b1; b2a_oe_n = 1'b0;
    pa_i = 18'h11111; pb_i = 18'h22222; step();
    chk1("R9 both drive", pb_oe & pa_oe, 1'b1);
    chk("R9 B word", pb_o, 18'h11111);
    chk("R9 A word", pa_o, 18'h22222);

    // Output enables off
    a2b_oe = 1'b0; b2a_oe_n = 1'b1; step();
    chk1("R5 B off", pb_oe, 1'b0);
    chk1("R6 A off", pa_oe, 1'b0);

    // Sweep over all control combinations with pseudo-random words
    for (int i = 0; i < 4000; i++) begin
      lfsr = nxt(lfsr);
      a2b_le = lfsr[0] & lfsr[1]; a2b_stb = lfsr[2]; a2b_oe = lfsr[3] | lfsr[4];
      b2a_le = lfsr[5] & lfsr[6]; b2a_stb = lfsr[7]; b2a_oe_n = lfsr[8] & lfsr[9];
      pa_i = lfsr[27:10];
      lfsr = nxt(lfsr);
      pb_i = lfsr[17:0];
      step();
      check_ports(mode_tag(a2b_le, r_ab, l_ab), mode_tag(b2a_le, r_ba, l_ba));
    end

    $display("[TB] note: %0d cycles with both ports driving", n_cont);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule